// File: doc/BRIEF.md
# Dual-Width Up Counter with Selectable Tick Source

This block is a free-standing up counter that runs either 8 bits or 16 bits wide. Each cycle it may advance by one, gated by a timer-clock enable. A 3-bit source selector produces that enable. The source is one of several prescaled ticks, every system clock, or a synchronised edge of an external pin. The selector can also stop the counter altogether.

The counter climbs from zero to an upper limit, returns to zero on the next enable and reports the wrap as an overflow event. The limit is either the largest value the current width can hold, or a value taken from the compare inputs. In 8-bit mode the compare input A alone supplies the limit. In 16-bit mode A is the low byte and B is the high byte of one compare word.

A synchronous load port lets the surrounding logic preset the count. A sticky overflow flag, cleared by a write-one strobe, lets slower logic notice wraps it would otherwise miss.

Top module: `dual_width_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `count` becomes 0 and both `ovf_pulse` and `ovf_flag` become 0.
- R2: With `clk_sel` = 3'b000 and no load, `count` keeps its value.
- R3: With `clk_sel` = 3'b001, the counter advances on every clock. In 8-bit mode with `top_from_cmp` = 0 it goes from 0xFF to 0x00.
- R4: With `clk_sel` = 3'b010, 3'b011, 3'b100 and 3'b101, consecutive increments are 8, 64, 256 and 1024 clocks apart.
- R5: `clk_sel` = 3'b111 counts rising edges and 3'b110 counts falling edges of `ext_pin`. The opposite edge has no effect. Each counted edge adds exactly one, no later than 3 clocks after the pin changes.
- R6: In 8-bit mode with `top_from_cmp` = 1, the count runs 0..`cmp_a` and then returns to 0 on the next enable. With `cmp_a` = 0 the count stays at 0 and every enable is an overflow.
- R7: In 16-bit mode the limit is 0xFFFF when `top_from_cmp` = 0. When `top_from_cmp` = 1 the limit is {`cmp_b`,`cmp_a`}, with `cmp_b` as the high byte.
- R8: A wrap to 0 raises `ovf_pulse` for exactly one cycle and sets `ovf_flag`. The flag stays set until `ovf_clr` is high at a clock edge. If a wrap and a clear happen in the same cycle, the flag stays set.
- R9: In 8-bit mode `count[15:8]` is 0 from the clock after the mode is selected. A load in that mode keeps only the low byte.
- R10: When `load_en` is high, `count` takes `load_val` at that edge in place of any increment, and no overflow is reported for that cycle.
- R11: A count above a compare limit keeps rising to the width's maximum. It then wraps to 0 with an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 3 | Tick source: 000 stop, 001 every clock, 010 /8, 011 /64, 100 /256, 101 /1024, 110 pin falling, 111 pin rising |
| wide_mode | input | 1 | 1 = 16-bit counting, 0 = 8-bit counting |
| top_from_cmp | input | 1 | 1 = limit from compare inputs, 0 = limit is the width maximum |
| cmp_a | input | 8 | Compare byte A (low byte in 16-bit mode) |
| cmp_b | input | 8 | Compare byte B (high byte in 16-bit mode) |
| ext_pin | input | 1 | Asynchronous external count input |
| load_en | input | 1 | Load strobe for the count |
| load_val | input | 16 | Value to load |
| ovf_clr | input | 1 | Write-one-to-clear for the sticky flag |
| count | output | 16 | Current count |
| ovf_pulse | output | 1 | One-cycle wrap indication |
| ovf_flag | output | 1 | Sticky wrap indication |

## Verification
Every internal fault here surfaces on `count` within one enable. A wrong limit shows up as a missing or early return to zero. A dropped upper-byte clear shows up as a nonzero high byte on the clock after 8-bit mode is selected. A faulty prescaler tap shows up as the wrong gap between two increments, so it needs at most 2048 clocks to expose. Synchroniser or edge-select faults appear as a count that moves on the wrong pin edge, or not at all, within three clocks of a pin transition.

// File: rtl/tmr_pkg.sv
// Shared encodings for the dual-width timer.
// Assumes the 3-bit source selector layout listed in the brief.
package tmr_pkg;
    typedef enum logic [2:0] {
        SRC_STOP   = 3'b000,
        SRC_CLK    = 3'b001,
        SRC_DIV8   = 3'b010,
        SRC_DIV64  = 3'b011,
        SRC_DIV256 = 3'b100,
        SRC_DIV1K  = 3'b101,
        SRC_PIN_FALL = 3'b110,
        SRC_PIN_RISE = 3'b111
    } tick_src_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Free-running power-of-two divider. It raises one single-cycle tick per tap,
// once every 2**TAP_LOG[i] clocks. Assumes the taps are listed in rising order.
module tmr_prescaler #(
    parameter int NTAPS = 4,
    parameter int TAP_LOG [NTAPS] = '{3, 6, 8, 10}
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [NTAPS-1:0] tick
);
    localparam int DIV_W = TAP_LOG[NTAPS-1];

    logic [DIV_W-1:0] div_q;

    // Advance the shared divider on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // One tap per divide ratio: a tap fires when its low bits are all ones.
    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        assign tick[g] = &div_q[TAP_LOG[g]-1:0];
    end

    // The finest tap never fires on two clocks in a row (R4).
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick[0] |=> !tick[0]);
endmodule

// File: rtl/tmr_edge_sync.sv
// Two-flop synchroniser for an asynchronous pin, with rise and fall detection.
// Each detected edge gives a pulse one system clock long. Assumes the pin stays
// stable for more than one clock between changes.
module tmr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift the pin through the synchroniser and keep the previous stable level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
    assign fall = ~sync_q[SYNC_STAGES-1] & last_q;

    // A detected edge lasts exactly one clock (R5).
    assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/tmr_count_core.sv
// Count register with load, limit/maximum wrap, width masking and the overflow
// pulse and sticky flag. Assumes top_val and max_val already fit the chosen width.
module tmr_count_core #(
    parameter int HALF_W = 8,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wide,
    input  logic [CNT_W-1:0] top_val,
    input  logic [CNT_W-1:0] max_val,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_pulse,
    output logic             ovf_flag
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] width_mask;
    logic             wrap;

    assign width_mask = wide ? {CNT_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    assign wrap       = tick && !load_en && ((cnt_q == top_val) || (cnt_q == max_val));

    // Next count: a load wins, then an enabled increment or wrap, else hold.
    always_comb begin
        if (load_en)   cnt_next = load_val;
        else if (wrap) cnt_next = '0;
        else if (tick) cnt_next = cnt_q + 1'b1;
        else           cnt_next = cnt_q;
        cnt_next = cnt_next & width_mask;
    end

    // Register the count and the overflow indications.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            ovf_pulse <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            cnt_q     <= cnt_next;
            ovf_pulse <= wrap;
            if (wrap)         ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
        end
    end

    assign count = cnt_q;

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en && wide) |=> $stable(count));
    assert_upper_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |=> (count[CNT_W-1:HALF_W] == '0));
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && wide) |=> (count == $past(load_val)) && !ovf_pulse);
    assert_flag_follows_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ovf_flag);
    assert_wrap_lands_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count == '0));
endmodule

// File: rtl/dual_width_timer.sv
// Top of the dual-width timer. It picks the tick source, forms the limit and the
// maximum for the chosen width, and drives the count core. Assumes ext_pin is
// asynchronous and that all other inputs are synchronous to clk.
module dual_width_timer
    import tmr_pkg::*;
#(
    parameter int HALF_W = 8,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        clk_sel,
    input  logic              wide_mode,
    input  logic              top_from_cmp,
    input  logic [HALF_W-1:0] cmp_a,
    input  logic [HALF_W-1:0] cmp_b,
    input  logic              ext_pin,
    input  logic              load_en,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              ovf_clr,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_pulse,
    output logic              ovf_flag
);
    localparam int NTAPS = 4;

    logic [NTAPS-1:0] pre_tick;
    logic             pin_rise;
    logic             pin_fall;
    logic             tick;
    logic [CNT_W-1:0] max_val;
    logic [CNT_W-1:0] top_val;

    tmr_prescaler #(.NTAPS(NTAPS), .TAP_LOG('{3, 6, 8, 10})) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(pre_tick)
    );

    tmr_edge_sync #(.SYNC_STAGES(2)) u_pin (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(pin_rise), .fall(pin_fall)
    );

    // Tick source selection from the 3-bit selector.
    always_comb begin
        unique case (tick_src_e'(clk_sel))
            SRC_STOP:     tick = 1'b0;
            SRC_CLK:      tick = 1'b1;
            SRC_DIV8:     tick = pre_tick[0];
            SRC_DIV64:    tick = pre_tick[1];
            SRC_DIV256:   tick = pre_tick[2];
            SRC_DIV1K:    tick = pre_tick[3];
            SRC_PIN_FALL: tick = pin_fall;
            SRC_PIN_RISE: tick = pin_rise;
            default:      tick = 1'b0;
        endcase
    end

    // Width maximum and the limit: the fused compare word or byte A alone.
    always_comb begin
        max_val = wide_mode ? {CNT_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        if (!top_from_cmp) top_val = max_val;
        else if (wide_mode) top_val = {cmp_b, cmp_a};
        else                top_val = {{HALF_W{1'b0}}, cmp_a};
    end

    tmr_count_core #(.HALF_W(HALF_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wide(wide_mode),
        .top_val(top_val), .max_val(max_val), .load_en(load_en),
        .load_val(load_val), .ovf_clr(ovf_clr), .count(count),
        .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
    );

    // A stopped source never moves the count (R2).
    assert_stop_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'b000 && !load_en && wide_mode) |=> $stable(count));
endmodule

// File: tb/tb_dual_width_timer.sv
module tb_dual_width_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  clk_sel = 3'b000;
    logic        wide_mode = 1'b0;
    logic        top_from_cmp = 1'b0;
    logic [7:0]  cmp_a = 8'h00;
    logic [7:0]  cmp_b = 8'h00;
    logic        ext_pin = 1'b0;
    logic        load_en = 1'b0;
    logic [15:0] load_val = 16'h0000;
    logic        ovf_clr = 1'b0;
    logic [15:0] count;
    logic        ovf_pulse;
    logic        ovf_flag;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    dual_width_timer dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wide_mode(wide_mode),
        .top_from_cmp(top_from_cmp), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .ext_pin(ext_pin), .load_en(load_en), .load_val(load_val),
        .ovf_clr(ovf_clr), .count(count), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic load(input logic [15:0] v);
        load_val = v; load_en = 1'b1;
        step(1);
        load_en = 1'b0;
    endtask

    // Run every-clock counting and compare against an arithmetic model.
    task automatic sweep(input int top, input int maxv, input int start, input int n, input string req);
        int exp;
        logic wr;
        exp = start;
        for (int i = 0; i < n; i++) begin
            wr = (exp == top) || (exp == maxv);
            exp = wr ? 0 : exp + 1;
            step(1);
            check(count == 16'(exp) && ovf_pulse == wr, req, int'(count), exp);
        end
    endtask

    // Gap in clocks between two successive increments.
    task automatic gap(input logic [2:0] sel, input int expn, input string req);
        logic [15:0] c0;
        int n;
        clk_sel = 3'b000; wide_mode = 1'b1; top_from_cmp = 1'b0;
        load(16'h0000);
        clk_sel = sel;
        c0 = count; n = 0;
        while (count == c0 && n < 3000) begin step(1); n++; end
        c0 = count; n = 0;
        while (count == c0 && n < 3000) begin step(1); n++; end
        check(n == expn, req, n, expn);
    endtask

    initial begin
        logic [15:0] c0;
        step(3);
        check(count == 16'h0 && !ovf_pulse && !ovf_flag, "R1", int'(count), 0);
        rst_n = 1'b1;
        step(1);

        // R2: stopped source holds
        wide_mode = 1'b1; load(16'h1234);
        step(20);
        check(count == 16'h1234, "R2", int'(count), 16'h1234);

        // R3: every clock, 8-bit, wrap at 0xFF
        wide_mode = 1'b0; top_from_cmp = 1'b0;
        load(16'h00F0);
        clk_sel = 3'b001;
        sweep(255, 255, 16'hF0, 40, "R3");

        // R6: 8-bit limit from cmp_a, several limits including 0
        top_from_cmp = 1'b1;
        foreach (cmp_a_list[k]) begin
            clk_sel = 3'b000; cmp_a = cmp_a_list[k];
            load(16'h0000);
            clk_sel = 3'b001;
            sweep(cmp_a_list[k], 255, 0, 3 * (cmp_a_list[k] + 1), "R6");
        end

        // R11: above limit runs to max then wraps
        clk_sel = 3'b000; cmp_a = 8'd10;
        load(16'h00FC);
        clk_sel = 3'b001;
        sweep(10, 255, 16'hFC, 8, "R11");

        // R7: 16-bit maximum and fused compare word
        clk_sel = 3'b000; wide_mode = 1'b1; top_from_cmp = 1'b0;
        load(16'hFFFC);
        clk_sel = 3'b001;
        sweep(16'hFFFF, 16'hFFFF, 16'hFFFC, 6, "R7");
        clk_sel = 3'b000; top_from_cmp = 1'b1; cmp_a = 8'h02; cmp_b = 8'h01;
        load(16'h00FD);
        clk_sel = 3'b001;
        sweep(16'h0102, 16'hFFFF, 16'h00FD, 20, "R7");

        // R8: sticky flag, clear, clear versus wrap
        clk_sel = 3'b000;
        step(5);
        check(ovf_flag == 1'b1 && !ovf_pulse, "R8", int'(ovf_flag), 1);
        ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
        check(ovf_flag == 1'b0, "R8", int'(ovf_flag), 0);
        load(16'h0102);
        ovf_clr = 1'b1; clk_sel = 3'b001; step(1); ovf_clr = 1'b0; clk_sel = 3'b000;
        check(ovf_flag == 1'b1 && ovf_pulse && count == 16'h0, "R8", int'(ovf_flag), 1);
        step(1);
        check(!ovf_pulse, "R8", int'(ovf_pulse), 0);

        // R10: load beats an increment and a wrap
        clk_sel = 3'b001; load(16'h0102);
        check(count == 16'h0102, "R10", int'(count), 16'h0102);
        ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
        load(16'h0055);
        check(count == 16'h0055, "R10", int'(count), 16'h0055);
        check(!ovf_pulse, "R10", int'(ovf_pulse), 0);
        clk_sel = 3'b000;

        // R9: 8-bit mode clears upper byte and truncates loads
        load(16'h5678);
        wide_mode = 1'b0; step(1);
        check(count == 16'h0078, "R9", int'(count), 16'h0078);
        load(16'h12AB);
        check(count == 16'h00AB, "R9", int'(count), 16'h00AB);

        // R4: prescaled gaps
        gap(3'b010, 8, "R4");
        gap(3'b011, 64, "R4");
        gap(3'b100, 256, "R4");
        gap(3'b101, 1024, "R4");

        // R5: external pin edges
        clk_sel = 3'b000; wide_mode = 1'b1; top_from_cmp = 1'b0;
        load(16'h0000);
        clk_sel = 3'b111;
        ext_pin = 1'b1; step(3);
        check(count == 16'h1, "R5", int'(count), 1);
        ext_pin = 1'b0; step(4);
        check(count == 16'h1, "R5", int'(count), 1);
        clk_sel = 3'b110;
        ext_pin = 1'b1; step(4);
        check(count == 16'h1, "R5", int'(count), 1);
        ext_pin = 1'b0; step(3);
        check(count == 16'h2, "R5", int'(count), 2);
        c0 = count; step(5);
        check(count == c0, "R5", int'(count), int'(c0));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    int cmp_a_list [6] = '{0, 1, 2, 7, 100, 255};

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule